// File: doc/BRIEF.md
# Reset Jump and Phantom Controller

This block makes the processor start executing from this memory board after a reset. A reset trigger is taken from either the power-on clear line or the front-panel preset line, as an option selects. When the chosen trigger is released, the block enters a jump state. In that state every memory read is decoded as if its upper address bits held the base of a target window. The target is window B, or window A when the window-swap option is set. A phantom output stays asserted through the jump so that other memory boards keep off the bus.

The jump ends on the first read whose real address lies inside the target window. Phantom and the override fall on that same clock. Writes during the jump are never redirected and never end it. Two option inputs can turn phantom off alone or turn the whole jump off. The address decoding itself lives in a neighbouring decoder, which takes the override enable and the override upper bits from this block.

Top module: `bootjump_ctrl`

## Requirements
- R1: After `rst_n` is released, and before any trigger, `jump_active`, `ovr_en`, `phantom` and `ovr_hi` are all 0.
- R2: With `opt_use_preset`=0, a pulse on `por_clr` starts a jump, and a pulse on `panel_preset` has no effect on any output.
- R3: With `opt_use_preset`=1, a pulse on `panel_preset` starts a jump, and a pulse on `por_clr` has no effect on any output.
- R4: A jump does not start while the selected trigger is high. `jump_active` rises on the third rising clock edge after the trigger input falls, and it is still 0 after the second.
- R5: While `jump_active`=1, `ovr_hi` equals `win_b_base` when `opt_swap`=0 and `win_a_base` when `opt_swap`=1. While no jump is active, `ovr_hi` is 0.
- R6: `phantom` equals `jump_active` when `opt_no_phantom`=0. With `opt_no_phantom`=1, `phantom` stays 0 while the override still works.
- R7: With `opt_no_jump`=1, triggers are ignored and `jump_active`, `ovr_en` and `phantom` stay 0.
- R8: A read cycle (`bus_rd`=1) whose `bus_addr[ADDR_W-1:WIN_LOG2]` equals the target base ends the jump. After that clock edge, `jump_active`, `ovr_en` and `phantom` are 0. Reads outside the target window leave the jump running.
- R9: A write cycle (`bus_wr`=1, `bus_rd`=0) never ends the jump, even to the target window. `ovr_en` is 0 during a write cycle, and it is `jump_active` during any other cycle.
- R10: If the selected trigger is raised again during a jump, all outputs drop, and a new jump starts once the trigger is released again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| por_clr | input | 1 | Power-on clear trigger, active high, asynchronous |
| panel_preset | input | 1 | Front-panel preset trigger, active high, asynchronous |
| opt_use_preset | input | 1 | 1 selects the preset input as the trigger, 0 selects power-on clear |
| opt_swap | input | 1 | 1 makes window A the jump target, 0 makes window B the target |
| opt_no_phantom | input | 1 | 1 suppresses phantom generation |
| opt_no_jump | input | 1 | 1 disables the reset jump entirely |
| win_a_base | input | ADDR_W-WIN_LOG2 | Upper address bits of window A |
| win_b_base | input | ADDR_W-WIN_LOG2 | Upper address bits of window B |
| bus_addr | input | ADDR_W | Real bus address of the current cycle |
| bus_rd | input | 1 | Memory read or fetch cycle strobe, one clock per access |
| bus_wr | input | 1 | Memory write cycle strobe, one clock per access |
| phantom | output | 1 | Disables other memory boards during the jump |
| ovr_en | output | 1 | Tells the decoder to replace the upper address bits |
| ovr_hi | output | ADDR_W-WIN_LOG2 | Replacement upper address bits for the decoder |
| jump_active | output | 1 | The jump state is in progress |

## Verification
A sequencer stuck in the jump state would show at the ports as `phantom` and `ovr_en` still high on the clock after a target-window read, so it is caught one edge after the read. A trigger path with the wrong number of synchroniser stages, or one that fires on the wrong edge, moves the rise of `jump_active` away from the third edge after release, and this shows within four cycles. A wrong source or target selection shows at once as a jump that does not start, or as a wrong `ovr_hi`, on the first cycle of the jump.

// File: rtl/bootjump_pkg.sv
package bootjump_pkg;

   typedef enum logic [1:0] {
      BJ_IDLE = 2'd0,
      BJ_HELD = 2'd1,
      BJ_JUMP = 2'd2
   } bj_state_e;

   localparam int BJ_NUM_SRC = 2;
   localparam int BJ_SRC_POR = 0;
   localparam int BJ_SRC_PRESET = 1;

endpackage

// File: rtl/bj_trig_sync.sv
module bj_trig_sync
   import bootjump_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic por_clr,
   input  logic panel_preset,
   input  logic use_preset,
   output logic trig_s
);

   logic [BJ_NUM_SRC-1:0] raw;
   logic [BJ_NUM_SRC-1:0] synced;

   assign raw[BJ_SRC_POR]    = por_clr;
   assign raw[BJ_SRC_PRESET] = panel_preset;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bj_trig_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < BJ_NUM_SRC; s++) begin : g_src
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '0;
            end else begin
               chain <= {chain[STAGES-2:0], raw[s]};
            end
         end
         assign synced[s] = chain[STAGES-1];
      end
   endgenerate

   always_comb begin
      trig_s = use_preset ? synced[BJ_SRC_PRESET] : synced[BJ_SRC_POR];
   end

endmodule

// File: rtl/bj_target_sel.sv
module bj_target_sel #(
   parameter int ADDR_W   = 16,
   parameter int WIN_LOG2 = 13,
   localparam int WIN_W   = ADDR_W - WIN_LOG2
) (
   input  logic              swap,
   input  logic [WIN_W-1:0]  base_a,
   input  logic [WIN_W-1:0]  base_b,
   input  logic [ADDR_W-1:0] addr,
   output logic [WIN_W-1:0]  target,
   output logic              addr_hit
);

   logic [WIN_W-1:0] addr_hi;

   generate
      if (WIN_W < 1) begin : g_bad_width
         $error("bj_target_sel: ADDR_W must exceed WIN_LOG2");
      end
   endgenerate

   assign addr_hi = addr[ADDR_W-1:WIN_LOG2];

   always_comb begin
      target   = swap ? base_a : base_b;
      addr_hit = (addr_hi == target);
   end

endmodule

// File: rtl/bj_seq.sv
module bj_seq
   import bootjump_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic trig_s,
   input  logic disable_jump,
   input  logic rd,
   input  logic hit,
   output logic in_jump
);

   bj_state_e st, st_nxt;

   always_comb begin
      st_nxt = st;
      case (st)
         BJ_IDLE: if (trig_s) st_nxt = BJ_HELD;
         BJ_HELD: if (!trig_s) st_nxt = BJ_JUMP;
         BJ_JUMP: begin
            if (trig_s) begin
               st_nxt = BJ_HELD;
            end else if (rd && hit) begin
               st_nxt = BJ_IDLE;
            end
         end
         default: st_nxt = BJ_IDLE;
      endcase
      if (disable_jump) begin
         st_nxt = BJ_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= BJ_IDLE;
      end else begin
         st <= st_nxt;
      end
   end

   assign in_jump = (st == BJ_JUMP);

endmodule

// File: rtl/bootjump_ctrl.sv
module bootjump_ctrl #(
   parameter int ADDR_W      = 16,
   parameter int WIN_LOG2    = 13,
   parameter int SYNC_STAGES = 2,
   localparam int WIN_W      = ADDR_W - WIN_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_clr,
   input  logic              panel_preset,
   input  logic              opt_use_preset,
   input  logic              opt_swap,
   input  logic              opt_no_phantom,
   input  logic              opt_no_jump,
   input  logic [WIN_W-1:0]  win_a_base,
   input  logic [WIN_W-1:0]  win_b_base,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   output logic              phantom,
   output logic              ovr_en,
   output logic [WIN_W-1:0]  ovr_hi,
   output logic              jump_active
);

   logic             trig_s;
   logic [WIN_W-1:0] target;
   logic             addr_hit;
   logic             in_jump;

   generate
      if (WIN_LOG2 < 1 || WIN_LOG2 >= ADDR_W) begin : g_bad_geom
         $error("bootjump_ctrl: WIN_LOG2 must lie in 1..ADDR_W-1");
      end
   endgenerate

   bj_trig_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk          (clk),
      .rst_n        (rst_n),
      .por_clr      (por_clr),
      .panel_preset (panel_preset),
      .use_preset   (opt_use_preset),
      .trig_s       (trig_s)
   );

   bj_target_sel #(
      .ADDR_W   (ADDR_W),
      .WIN_LOG2 (WIN_LOG2)
   ) u_tgt (
      .swap     (opt_swap),
      .base_a   (win_a_base),
      .base_b   (win_b_base),
      .addr     (bus_addr),
      .target   (target),
      .addr_hit (addr_hit)
   );

   bj_seq u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .trig_s       (trig_s),
      .disable_jump (opt_no_jump),
      .rd           (bus_rd),
      .hit          (addr_hit),
      .in_jump      (in_jump)
   );

   always_comb begin
      jump_active = in_jump;
      phantom     = in_jump && !opt_no_phantom;
      ovr_en      = in_jump && !(bus_wr && !bus_rd);
      ovr_hi      = in_jump ? target : '0;
   end

endmodule

// File: rtl/bootjump_chk.sv
module bootjump_chk #(
   parameter int ADDR_W   = 16,
   parameter int WIN_LOG2 = 13,
   localparam int WIN_W   = ADDR_W - WIN_LOG2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              opt_swap,
   input logic              opt_no_jump,
   input logic [WIN_W-1:0]  win_a_base,
   input logic [WIN_W-1:0]  win_b_base,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              trig_s,
   input logic              phantom,
   input logic              ovr_en,
   input logic [WIN_W-1:0]  ovr_hi,
   input logic              jump_active
);

   logic [WIN_W-1:0] exp_tgt;
   assign exp_tgt = opt_swap ? win_a_base : win_b_base;

   AST_PHANTOM_IN_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
      phantom |-> jump_active); // R6

   AST_OVR_IN_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_en |-> jump_active); // R9

   AST_OVR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      jump_active |-> ovr_hi == exp_tgt); // R5

   AST_NOJUMP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(opt_no_jump) |-> !jump_active); // R7

   AST_ENTRY_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(jump_active) |-> !$past(trig_s)); // R4

   AST_END_ON_TARGET_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (jump_active && bus_rd && bus_addr[ADDR_W-1:WIN_LOG2] == exp_tgt) |=> !jump_active); // R8

   AST_WRITE_NO_END: assert property (@(posedge clk) disable iff (!rst_n)
      (jump_active && !bus_rd && !trig_s && !opt_no_jump) |=> jump_active); // R9

   AST_RETRIGGER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (jump_active && trig_s) |=> !jump_active); // R10

endmodule

bind bootjump_ctrl bootjump_chk #(
   .ADDR_W   (ADDR_W),
   .WIN_LOG2 (WIN_LOG2)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .opt_swap    (opt_swap),
   .opt_no_jump (opt_no_jump),
   .win_a_base  (win_a_base),
   .win_b_base  (win_b_base),
   .bus_addr    (bus_addr),
   .bus_rd      (bus_rd),
   .trig_s      (trig_s),
   .phantom     (phantom),
   .ovr_en      (ovr_en),
   .ovr_hi      (ovr_hi),
   .jump_active (jump_active)
);

// File: tb/tb_bootjump_ctrl.sv
`timescale 1ns/1ps
module tb_bootjump_ctrl;
   localparam int ADDR_W = 16;
   localparam int WIN_LOG2 = 13;
   localparam int WIN_W = ADDR_W - WIN_LOG2;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, por_clr, panel_preset, opt_use_preset, opt_swap;
   logic opt_no_phantom, opt_no_jump, bus_rd, bus_wr;
   logic [WIN_W-1:0] win_a_base, win_b_base;
   logic [ADDR_W-1:0] bus_addr;
   logic phantom, ovr_en, jump_active;
   logic [WIN_W-1:0] ovr_hi;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit exp_j;

   bootjump_ctrl #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .por_clr(por_clr), .panel_preset(panel_preset),
      .opt_use_preset(opt_use_preset), .opt_swap(opt_swap),
      .opt_no_phantom(opt_no_phantom), .opt_no_jump(opt_no_jump),
      .win_a_base(win_a_base), .win_b_base(win_b_base), .bus_addr(bus_addr),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .phantom(phantom), .ovr_en(ovr_en),
      .ovr_hi(ovr_hi), .jump_active(jump_active));

   function automatic logic [WIN_W-1:0] tgt_f();
      return opt_swap ? win_a_base : win_b_base;
   endfunction

   function automatic logic [ADDR_W-1:0] mk_addr(logic [WIN_W-1:0] hi, logic [WIN_LOG2-1:0] lo);
      return {hi, lo};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic step(int n);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic chk_all(string req, bit ej);
      bit wr_only;
      wr_only = bus_wr && !bus_rd;
      chk({req, " jump_active"}, 32'(jump_active), 32'(ej));
      chk({req, " ovr_en"}, 32'(ovr_en), 32'(ej && !wr_only));
      chk({req, " phantom"}, 32'(phantom), 32'(ej && !opt_no_phantom));
      chk({req, " ovr_hi"}, 32'(ovr_hi), ej ? 32'(tgt_f()) : 32'd0);
   endtask

   task automatic set_src(bit src, bit v);
      if (src) panel_preset = v;
      else por_clr = v;
   endtask

   // Pulse a trigger source; works reports whether a jump is expected.
   task automatic pulse(string req, bit src, bit works);
      set_src(src, 1'b1);
      step(4);
      chk({req, " R4 held"}, 32'(jump_active), 32'd0);
      set_src(src, 1'b0);
      step(2);
      chk({req, " R4 second edge"}, 32'(jump_active), 32'd0);
      step(1);
      chk_all({req, " R4 third edge"}, works);
      exp_j = works;
   endtask

   task automatic access(string req, bit rd, bit wr, logic [ADDR_W-1:0] a);
      bus_rd = rd;
      bus_wr = wr;
      bus_addr = a;
      #1;
      chk_all({req, " during"}, exp_j);
      step(1);
      if (rd && a[ADDR_W-1:WIN_LOG2] == tgt_f()) exp_j = 1'b0;
      bus_rd = 1'b0;
      bus_wr = 1'b0;
      #0;
      chk_all({req, " after"}, exp_j);
   endtask

   task automatic end_jump();
      access("end R8", 1'b1, 1'b0, mk_addr(tgt_f(), '0));
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; por_clr = 1'b0; panel_preset = 1'b0;
      opt_use_preset = 1'b0; opt_swap = 1'b0; opt_no_phantom = 1'b0; opt_no_jump = 1'b0;
      win_a_base = 3'd2; win_b_base = 3'd6; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0;
      exp_j = 1'b0;
      step(3);
      rst_n = 1'b1;
      step(2);
      chk_all("R1 reset", 1'b0);

      // R2: default source is power-on clear, target window B
      pulse("R2 por", 1'b0, 1'b1);
      chk("R5 target B", 32'(ovr_hi), 32'd6);
      chk("R6 phantom on", 32'(phantom), 32'd1);
      access("R8 read outside", 1'b1, 1'b0, mk_addr(3'd1, 13'h0123));
      access("R9 write target", 1'b0, 1'b1, mk_addr(3'd6, 13'h0010));
      chk("R9 write no end", 32'(jump_active), 32'd1);
      access("R8 read target", 1'b1, 1'b0, mk_addr(3'd6, 13'h1fff));
      chk("R8 ended", 32'(jump_active), 32'd0);
      pulse("R2 preset ignored", 1'b1, 1'b0);

      // R3: preset selected
      opt_use_preset = 1'b1;
      step(1);
      pulse("R3 por ignored", 1'b0, 1'b0);
      pulse("R3 preset", 1'b1, 1'b1);
      end_jump();

      // R5: swap selects window A
      opt_swap = 1'b1;
      pulse("R5 swap", 1'b1, 1'b1);
      chk("R5 target A", 32'(ovr_hi), 32'd2);
      access("R5 read B no end", 1'b1, 1'b0, mk_addr(3'd6, 13'h0000));
      end_jump();

      // R6: phantom disabled, override kept
      opt_no_phantom = 1'b1;
      pulse("R6 no phantom", 1'b1, 1'b1);
      chk("R6 phantom off", 32'(phantom), 32'd0);
      chk("R6 override on", 32'(ovr_en), 32'd1);
      end_jump();
      opt_no_phantom = 1'b0;

      // R7: jump disabled
      opt_no_jump = 1'b1;
      step(1);
      pulse("R7 no jump", 1'b1, 1'b0);
      step(3);
      chk_all("R7 still quiet", 1'b0);
      opt_no_jump = 1'b0;
      step(1);

      // R10: re-trigger during a jump
      pulse("R10 first", 1'b1, 1'b1);
      panel_preset = 1'b1;
      step(3);
      chk_all("R10 cancelled", 1'b0);
      panel_preset = 1'b0;
      step(3);
      chk_all("R10 restarted", 1'b1);
      exp_j = 1'b1;
      end_jump();

      // Random mix
      for (int it = 0; it < 250; it++) begin
         int n;
         bit src;
         opt_use_preset = 1'($urandom_range(0, 1));
         opt_swap       = 1'($urandom_range(0, 1));
         opt_no_phantom = 1'($urandom_range(0, 1));
         opt_no_jump    = ($urandom_range(0, 7) == 0);
         win_a_base     = 3'($urandom_range(0, 7));
         win_b_base     = 3'($urandom_range(0, 7));
         src            = 1'($urandom_range(0, 1));
         step(1);
         pulse("R2 R3 R7 random start", src, (src == opt_use_preset) && !opt_no_jump);
         n = $urandom_range(4, 20);
         for (int k = 0; k < n; k++) begin
            int kind;
            logic [WIN_W-1:0] hi;
            kind = $urandom_range(0, 2);
            hi = ($urandom_range(0, 3) == 0) ? tgt_f() : 3'($urandom_range(0, 7));
            access("R8 R9 random access", kind == 1, kind == 2,
                   mk_addr(hi, 13'($urandom_range(0, 8191))));
         end
         if (exp_j) end_jump();
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule